// File: doc/BRIEF.md
# Multiplexed ADC Readout Sequencer

This block runs the readout of one event from an analog front end whose channels are presented one after another through an external multiplexer. A start request opens the event. The block raises a hold line and pulses the multiplexer reset, in an order chosen by configuration. It then advances the multiplexer one step per clock pulse. After each step it waits a programmable settle time and strobes the ADC. Each converted value is returned on a sample stream that carries a channel index.

The recorded event always holds 18 samples. The multiplexer can be stepped either 18 or 19 times. The extra step keeps the multiplexer output line driven after the last real channel instead of leaving it floating. When it is used, the conversion that belongs to it is dropped from the sample stream, so the data volume does not change. Configuration is captured when a start is accepted. A done pulse closes the event and drops hold.

Top module: `mux_readout_seq`

## Requirements
- R1: While rst_ni is low, and after its release with no start, hold_o, mux_clk_o, mux_rst_o, adc_conv_o, smp_valid_o and done_o are all low. This holds even if reset arrives in the middle of a sequence.
- R2: With reset_after_i = 0 at start, mux_rst_o pulses for one cycle in the first cycle after the start edge, and hold_o rises in the next cycle.
- R3: With reset_after_i = 1 at start, hold_o rises in the first cycle after the start edge, and mux_rst_o pulses for one cycle in the next cycle while hold_o stays high.
- R4: One event gives 18 mux_clk_o pulses and 18 adc_conv_o pulses when extra_read_i = 0 at start, and 19 of each when extra_read_i = 1.
- R5: Each adc_conv_o pulse comes exactly settle_i + 1 cycles after the mux_clk_o pulse of the same step.
- R6: Exactly 18 samples are flagged by smp_valid_o per event, with smp_idx_o counting 0 to 17 in order. The conversion of a 19th step never appears.
- R7: smp_valid_o is high for one cycle, two cycles after the matching adc_conv_o pulse. smp_data_o then equals the value adc_data_i held in the cycle after that pulse.
- R8: A start_i that arrives while a sequence is running is ignored. The running event keeps its counts, and no second reset pulse or restart occurs.
- R9: done_o pulses once, in the cycle after the last adc_conv_o pulse. hold_o is low in that cycle.
- R10: extra_read_i, reset_after_i and settle_i are captured when a start is accepted. Changing them later has no effect on the running event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| extra_read_i | input | 1 | 1: step 19 times and drop the last conversion; 0: step 18 times |
| reset_after_i | input | 1 | 1: multiplexer reset after hold; 0: before hold |
| settle_i | input | SETTLE_W (4) | Cycles between a multiplexer step and its conversion strobe |
| adc_data_i | input | DATA_W (12) | ADC result, valid in the cycle after a conversion strobe |
| hold_o | output | 1 | Hold line to the front end |
| mux_clk_o | output | 1 | Multiplexer step pulse |
| mux_rst_o | output | 1 | Multiplexer reset pulse |
| adc_conv_o | output | 1 | ADC conversion strobe |
| smp_valid_o | output | 1 | Recorded sample valid |
| smp_idx_o | output | IDX_W (5) | Channel index of the recorded sample |
| smp_data_o | output | DATA_W (12) | Recorded sample value |
| done_o | output | 1 | End-of-event pulse |

## Verification
The hardest case to reach is the masked final conversion. It must be strobed but never appear on the sample stream, and it lands in the same cycles as done_o and the fall of hold_o. The bench runs the 19-step mode at several settle values, including zero. There the step and conversion pulses come back to back. The bench counts strobes and samples separately, and it ties each sample to its strobe cycle. It also changes every configuration input and repeats start requests in mid-event, to show that the captured settings alone decide the event.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_POST,
    ST_MCLK,
    ST_SETTLE,
    ST_CONV,
    ST_DONE
  } mrs_state_e;
endpackage

// File: rtl/mrs_cnt.sv
module mrs_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
#(
  parameter int N_KEEP   = 18,
  parameter int SETTLE_W = 4,
  parameter int IDX_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                extra_read_i,
  input  logic                reset_after_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                hold_o,
  output logic                mux_clk_o,
  output logic                mux_rst_o,
  output logic                conv_o,
  output logic                done_o,
  output logic [IDX_W-1:0]    step_o,
  output logic                cfg_after_o
);
  mrs_state_e state_q, state_d;
  logic                extra_q, after_q;
  logic [SETTLE_W-1:0] settle_q, settle_cnt;
  logic [IDX_W-1:0]    step_cnt, step_last_idx;
  logic                accept, settle_end, step_last;

  assign accept = (state_q == ST_IDLE) && start_i;

  // configuration is frozen for the whole event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      extra_q  <= 1'b0;
      after_q  <= 1'b0;
      settle_q <= '0;
    end else if (accept) begin
      extra_q  <= extra_read_i;
      after_q  <= reset_after_i;
      settle_q <= settle_i;
    end
  end

  mrs_cnt #(.W(SETTLE_W)) u_settle_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_SETTLE),
    .inc_i  (state_q == ST_SETTLE),
    .q_o    (settle_cnt)
  );

  mrs_cnt #(.W(IDX_W)) u_step_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .inc_i  (state_q == ST_CONV),
    .q_o    (step_cnt)
  );

  assign step_last_idx = IDX_W'(N_KEEP - 1) + IDX_W'(extra_q);
  assign step_last     = (step_cnt == step_last_idx);
  assign settle_end    = (settle_cnt == settle_q - 1'b1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_PRE;
      ST_PRE:    state_d = ST_POST;
      ST_POST:   state_d = ST_MCLK;
      ST_MCLK:   state_d = (settle_q == '0) ? ST_CONV : ST_SETTLE;
      ST_SETTLE: if (settle_end) state_d = ST_CONV;
      ST_CONV:   state_d = step_last ? ST_DONE : ST_MCLK;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign mux_rst_o = ((state_q == ST_PRE) && !after_q) || ((state_q == ST_POST) && after_q);
  assign hold_o    = ((state_q == ST_PRE) && after_q) || (state_q == ST_POST) ||
                     (state_q == ST_MCLK) || (state_q == ST_SETTLE) || (state_q == ST_CONV);
  assign mux_clk_o   = (state_q == ST_MCLK);
  assign conv_o      = (state_q == ST_CONV);
  assign done_o      = (state_q == ST_DONE);
  assign step_o      = step_cnt;
  assign cfg_after_o = after_q;
endmodule

// File: rtl/mrs_capture.sv
module mrs_capture #(
  parameter int N_KEEP = 18,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic [IDX_W-1:0]  step_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  logic             conv_q;
  logic [IDX_W-1:0] step_q;
  logic             keep;

  // steps at or beyond N_KEEP are conversions for line hold only
  assign keep = (step_q < IDX_W'(N_KEEP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q  <= 1'b0;
      step_q  <= '0;
      valid_o <= 1'b0;
      idx_o   <= '0;
      data_o  <= '0;
    end else begin
      conv_q  <= conv_i;
      if (conv_i) step_q <= step_i;
      valid_o <= conv_q && keep;
      if (conv_q && keep) begin
        idx_o  <= step_q;
        data_o <= adc_data_i;
      end
    end
  end
endmodule

// File: rtl/mux_readout_seq.sv
module mux_readout_seq #(
  parameter int N_KEEP   = 18,
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 4,
  localparam int IDX_W   = $clog2(N_KEEP + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                extra_read_i,
  input  logic                reset_after_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [DATA_W-1:0]   adc_data_i,
  output logic                hold_o,
  output logic                mux_clk_o,
  output logic                mux_rst_o,
  output logic                adc_conv_o,
  output logic                smp_valid_o,
  output logic [IDX_W-1:0]    smp_idx_o,
  output logic [DATA_W-1:0]   smp_data_o,
  output logic                done_o
);
  logic [IDX_W-1:0] step;
  logic             cfg_after;

  mrs_ctrl #(
    .N_KEEP   (N_KEEP),
    .SETTLE_W (SETTLE_W),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .extra_read_i  (extra_read_i),
    .reset_after_i (reset_after_i),
    .settle_i      (settle_i),
    .hold_o        (hold_o),
    .mux_clk_o     (mux_clk_o),
    .mux_rst_o     (mux_rst_o),
    .conv_o        (adc_conv_o),
    .done_o        (done_o),
    .step_o        (step),
    .cfg_after_o   (cfg_after)
  );

  mrs_capture #(
    .N_KEEP (N_KEEP),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_i     (adc_conv_o),
    .step_i     (step),
    .adc_data_i (adc_data_i),
    .valid_o    (smp_valid_o),
    .idx_o      (smp_idx_o),
    .data_o     (smp_data_o)
  );
endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
  parameter int N_KEEP = 18,
  parameter int IDX_W  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_o,
  input logic             mux_clk_o,
  input logic             mux_rst_o,
  input logic             adc_conv_o,
  input logic             done_o,
  input logic             smp_valid_o,
  input logic [IDX_W-1:0] smp_idx_o,
  input logic             cfg_after
);
  a_r2_rst_then_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hold_o) && !cfg_after) |-> $past(mux_rst_o));

  a_r3_rst_inside_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_rst_o && cfg_after) |-> hold_o);

  a_r4_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mux_clk_o, adc_conv_o, mux_rst_o, done_o}));

  a_r6_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> (smp_idx_o < IDX_W'(N_KEEP)));

  a_r7_valid_after_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(adc_conv_o, 2));

  a_r9_done_after_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!hold_o && $past(adc_conv_o)));

  a_r9_hold_falls_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> done_o);
endmodule

bind mux_readout_seq mrs_checker #(
  .N_KEEP (N_KEEP),
  .IDX_W  (IDX_W)
) u_mrs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hold_o      (hold_o),
  .mux_clk_o   (mux_clk_o),
  .mux_rst_o   (mux_rst_o),
  .adc_conv_o  (adc_conv_o),
  .done_o      (done_o),
  .smp_valid_o (smp_valid_o),
  .smp_idx_o   (smp_idx_o),
  .cfg_after   (cfg_after)
);

// File: tb/mux_readout_seq_tb_top.sv
module mux_readout_seq_tb_top;
  localparam int N_KEEP   = 18;
  localparam int DATA_W   = 12;
  localparam int SETTLE_W = 4;
  localparam int IDX_W    = $clog2(N_KEEP + 1);

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 1'b0;
  logic                extra_read_i = 1'b0;
  logic                reset_after_i = 1'b0;
  logic [SETTLE_W-1:0] settle_i = '0;
  logic [DATA_W-1:0]   adc_data_i = '0;
  logic                hold_o, mux_clk_o, mux_rst_o, adc_conv_o, smp_valid_o, done_o;
  logic [IDX_W-1:0]    smp_idx_o;
  logic [DATA_W-1:0]   smp_data_o;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #2 clk_i = ~clk_i;

  mux_readout_seq #(.N_KEEP(N_KEEP), .DATA_W(DATA_W), .SETTLE_W(SETTLE_W)) dut_i (
    .clk_i, .rst_ni, .start_i, .extra_read_i, .reset_after_i, .settle_i, .adc_data_i,
    .hold_o, .mux_clk_o, .mux_rst_o, .adc_conv_o, .smp_valid_o, .smp_idx_o, .smp_data_o,
    .done_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int k);
    return DATA_W'(k * 149 + 7) ^ DATA_W'(12'h5A3);
  endfunction

  function automatic int quiet();
    return int'({hold_o, mux_clk_o, mux_rst_o, adc_conv_o, smp_valid_o, done_o});
  endfunction

  task automatic t_reset_state();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(quiet() == 0, "R1", "outputs in reset", quiet(), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(quiet() == 0, "R1", "outputs idle after reset", quiet(), 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk_i);
    extra_read_i = 1'b1; reset_after_i = 1'b0; settle_i = 4'd1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(quiet() == 0, "R1", "outputs on mid-run reset", quiet(), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(quiet() == 0, "R1", "idle after mid-run reset", quiet(), 0);
  endtask

  task automatic run_seq(input bit extra, input bit after, input int settle,
                         input bit busy_start, input bit cfg_flip);
    int c = 1, mclk_n = 0, conv_n = 0, val_n = 0, done_n = 0, rst_n = 0;
    int rst_c = 0, hold_c = 0, last_mclk = 0, last_conv = 0, done_c = 0;
    int conv_c[64];
    int n_reads = N_KEEP + int'(extra);
    bit hold_prev = 1'b0;
    @(negedge clk_i);
    extra_read_i = extra; reset_after_i = after; settle_i = SETTLE_W'(settle); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (cfg_flip) begin
      extra_read_i = ~extra; reset_after_i = ~after; settle_i = SETTLE_W'(settle ^ 3);
    end
    while (c < 2000 && (done_c == 0 || c < done_c + 4)) begin
      if (mux_rst_o) begin rst_n++; rst_c = c; end
      if (hold_o && !hold_prev) hold_c = c;
      hold_prev = hold_o;
      if (mux_clk_o) begin mclk_n++; last_mclk = c; end
      if (adc_conv_o) begin
        chk(c - last_mclk == settle + 1, "R5", "step to strobe gap", c - last_mclk, settle + 1);
        if (conv_n < 64) conv_c[conv_n] = c;
        adc_data_i = pat(conv_n);
        conv_n++;
        last_conv = c;
      end
      if (smp_valid_o) begin
        chk(int'(smp_idx_o) == val_n, "R6", "sample index", int'(smp_idx_o), val_n);
        chk(smp_data_o == pat(val_n), "R7", "sample data", int'(smp_data_o), int'(pat(val_n)));
        if (val_n < 64)
          chk(c == conv_c[val_n] + 2, "R7", "valid cycle", c, conv_c[val_n] + 2);
        val_n++;
      end
      if (done_o) begin
        done_n++; done_c = c;
        chk(c == last_conv + 1, "R9", "done cycle", c, last_conv + 1);
        chk(!hold_o, "R9", "hold at done", int'(hold_o), 0);
      end
      start_i = busy_start && c >= 3 && c <= 12;
      @(negedge clk_i);
      c++;
    end
    start_i = 1'b0;
    chk(rst_n == 1, after ? "R3" : "R2", "reset pulses", rst_n, 1);
    if (!after) begin
      chk(rst_c == 1, "R2", "reset cycle", rst_c, 1);
      chk(hold_c == 2, "R2", "hold rise cycle", hold_c, 2);
    end else begin
      chk(hold_c == 1, "R3", "hold rise cycle", hold_c, 1);
      chk(rst_c == 2, "R3", "reset cycle", rst_c, 2);
    end
    chk(mclk_n == n_reads, "R4", "mux steps", mclk_n, n_reads);
    chk(conv_n == n_reads, "R4", "conversions", conv_n, n_reads);
    chk(val_n == N_KEEP, "R6", "recorded samples", val_n, N_KEEP);
    chk(done_n == 1, "R9", "done pulses", done_n, 1);
    if (busy_start) chk(rst_n == 1 && done_n == 1 && mclk_n == n_reads, "R8",
                        "busy start ignored", mclk_n, n_reads);
    if (cfg_flip) chk(mclk_n == n_reads && val_n == N_KEEP, "R10",
                      "config frozen at start", mclk_n, n_reads);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 100000, 0);
    finish_run();
  end

  initial begin
    t_reset_state();
    run_seq(1'b0, 1'b0, 0, 1'b0, 1'b0);
    run_seq(1'b1, 1'b0, 0, 1'b0, 1'b0);
    run_seq(1'b0, 1'b1, 2, 1'b0, 1'b0);
    run_seq(1'b1, 1'b1, 3, 1'b0, 1'b0);
    run_seq(1'b1, 1'b0, 5, 1'b1, 1'b0);
    run_seq(1'b0, 1'b0, 1, 1'b0, 1'b1);
    run_seq(1'b1, 1'b1, 0, 1'b0, 1'b1);
    t_reset_mid();
    run_seq(1'b1, 1'b0, 1, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule